// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Engine

This block computes the 32-bit cyclic redundancy check that protects an Ethernet frame. It takes one byte per clock. In transmit use, the frame bytes are fed in, and after the last byte the block presents the finished check word. It also streams that word out as four bytes, ready to append to the frame.

In receive use, the whole frame is fed through the same engine, including the four check bytes that arrived with it. When the last byte has been absorbed, the block raises `crc_ok` if the raw register holds the fixed good-frame remainder. The result is not reversed or inverted before this comparison.

The register is loaded with all ones on the first byte of every frame. Idle cycles inside a frame leave it untouched. Framing, preamble removal and the physical interface are handled elsewhere.

Top module: `eth_fcs_engine`

## Requirements
- R1: Bytes are absorbed least-significant bit first with generator polynomial 0x04C11DB7. The nine ASCII bytes "123456789" give `fcs_word` = 0xCBF43926.
- R2: A byte accepted with `sof` high is combined with an all-ones register, whatever the register held before. Identical frames sent back to back give identical results.
- R3: `fcs_word[i]` is the complement of register bit 31-i. Four zero bytes give 0x2144DF1C, and the single byte 0x61 gives 0xE8B7BE43.
- R4: On the four cycles that follow an accepted `eof` byte, `fcs_byte_valid` is high. `fcs_byte` carries `fcs_word[7:0]`, then `[15:8]`, then `[23:16]`, then `[31:24]`.
- R5: A frame followed by its own four check bytes (in R4 order, the last carrying `eof`) leaves the register at 0xC704DD7B. `crc_ok` is then high from the cycle after the `eof` byte.
- R6: If any byte of a received frame or its check bytes is altered, `crc_ok` stays low after the `eof` byte.
- R7: While `din_valid` is low, the register and `fcs_word` hold their values. A frame with idle gaps gives the same result as one without gaps.
- R8: `crc_ok` holds until the next accepted byte that lacks `eof` (such as the next frame's `sof` byte), which clears it in the following cycle.
- R9: After reset, `crc_ok` and `fcs_byte_valid` are low.
- R10: An accepted byte without `eof` ends any check-byte stream in progress. `fcs_byte_valid` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Marks the first byte of a frame |
| eof | input | 1 | Marks the last byte of a frame |
| din_valid | input | 1 | Byte on `din` is accepted this cycle |
| din | input | 8 | Data byte |
| fcs_word | output | 32 | Reversed and complemented register |
| fcs_byte | output | 8 | Current check byte of the stream |
| fcs_byte_valid | output | 1 | `fcs_byte` is valid |
| crc_ok | output | 1 | Received frame matched the good remainder |

## Verification
The embedded assertions check several things on every cycle:
- `fcs_word` stays stable across idle cycles.
- An `eof` byte starts the stream and puts the low check byte on `fcs_byte`.
- A non-`eof` byte clears both `crc_ok` and the stream.
- `crc_ok` is never high unless the register holds the good remainder.

The arithmetic itself is shown only by the bench scenarios, which compare against known check values and an independent right-shifting model. These scenarios cover:
- the order of the streamed bytes;
- receive loopback and corruption;
- gap tolerance;
- back-to-back frames.

// File: rtl/eth_fcs_engine.sv
module eth_fcs_engine #(
  parameter logic [31:0] POLY    = 32'h04C1_1DB7,
  parameter logic [31:0] GOOD    = 32'hC704_DD7B,
  parameter int          DW      = 8,
  parameter int          NBYTES  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          eof,
  input  logic          din_valid,
  input  logic [DW-1:0] din,
  output logic [31:0]   fcs_word,
  output logic [7:0]    fcs_byte,
  output logic          fcs_byte_valid,
  output logic          crc_ok
);
  localparam int CW = $clog2(NBYTES + 1);

  logic [31:0] crc_q, crc_d, seed;
  logic [CW-1:0] left_q;
  logic [CW-1:0] pos;

  function automatic logic [31:0] absorb(input logic [31:0] c, input logic [DW-1:0] d);
    logic fb;
    for (int i = 0; i < DW; i++) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  assign seed  = sof ? '1 : crc_q;
  assign crc_d = absorb(seed, din);

  generate
    for (genvar i = 0; i < 32; i++) begin : g_rev
      assign fcs_word[i] = ~crc_q[31-i];
    end
  endgenerate

  assign fcs_byte_valid = (left_q != '0);
  assign pos            = CW'(NBYTES) - left_q;
  assign fcs_byte       = fcs_byte_valid ? fcs_word[pos[1:0]*8 +: 8] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '1;
      left_q <= '0;
      crc_ok <= 1'b0;
    end else if (din_valid) begin
      crc_q  <= crc_d;
      left_q <= eof ? CW'(NBYTES) : '0;
      crc_ok <= eof && (crc_d == GOOD);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> $stable(fcs_word));

  // R4
  stream_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && eof) |=> (fcs_byte_valid && fcs_byte == fcs_word[7:0]));

  // R10
  stream_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && !eof) |=> (!fcs_byte_valid && !crc_ok));

  // R5
  ok_means_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> (crc_q == GOOD));

  // R8
  ok_rise_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_ok) |-> $past(din_valid && eof));
endmodule

// File: tb/eth_fcs_engine_test.sv
module eth_fcs_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, eof = 1'b0, din_valid = 1'b0;
  logic [7:0] din = 8'h00;
  logic [31:0] fcs_word;
  logic [7:0] fcs_byte;
  logic fcs_byte_valid, crc_ok;

  int checks = 0;
  int errors = 0;
  logic [7:0] fr [0:63];
  int flen;

  eth_fcs_engine uut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .din_valid(din_valid),
    .din(din), .fcs_word(fcs_word), .fcs_byte(fcs_byte),
    .fcs_byte_valid(fcs_byte_valid), .crc_ok(crc_ok)
  );

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_fcs(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      c ^= {24'h0, fr[k]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic put(input logic s, input logic e, input logic [7:0] d);
    @(negedge clk);
    sof = s; eof = e; din = d; din_valid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    sof = 1'b0; eof = 1'b0; din_valid = 1'b0;
  endtask

  task automatic send_frame(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      put(k == 0, k == n - 1, fr[k]);
      if (gap != 0 && k != n - 1) repeat (gap) idle();
    end
    idle();
  endtask

  task automatic load_ascii();
    for (int k = 0; k < 9; k++) fr[k] = 8'h31 + 8'(k);
    flen = 9;
  endtask

  task automatic t_reset();
    chk("R9 crc_ok", {31'h0, crc_ok}, 32'h0);
    chk("R9 fcs_byte_valid", {31'h0, fcs_byte_valid}, 32'h0);
  endtask

  task automatic t_known();
    load_ascii();
    send_frame(flen, 0);
    chk("R1 check value", fcs_word, 32'hCBF4_3926);
    chk("R1 model", fcs_word, model_fcs(flen));
    for (int k = 0; k < 4; k++) fr[k] = 8'h00;
    send_frame(4, 0);
    chk("R3 four zero bytes", fcs_word, 32'h2144_DF1C);
    fr[0] = 8'h61;
    send_frame(1, 0);
    chk("R3 single byte", fcs_word, 32'hE8B7_BE43);
  endtask

  task automatic t_stream();
    logic [31:0] exp;
    load_ascii();
    send_frame(flen, 0);
    exp = 32'hCBF4_3926;
    for (int k = 0; k < 4; k++) begin
      chk("R4 byte valid", {31'h0, fcs_byte_valid}, 32'h1);
      chk("R4 byte order", {24'h0, fcs_byte}, {24'h0, exp[k*8 +: 8]});
      idle();
    end
    chk("R4 stream ends", {31'h0, fcs_byte_valid}, 32'h0);
  endtask

  task automatic t_receive(input logic corrupt);
    logic [31:0] f;
    load_ascii();
    f = model_fcs(flen);
    for (int k = 0; k < 4; k++) fr[flen + k] = f[k*8 +: 8];
    if (corrupt) fr[3] = fr[3] ^ 8'h10;
    send_frame(flen + 4, 0);
    if (corrupt) chk("R6 corrupted frame", {31'h0, crc_ok}, 32'h0);
    else chk("R5 good frame", {31'h0, crc_ok}, 32'h1);
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 20; k++) fr[k] = 8'(k * 37 + 5);
    send_frame(20, 2);
    chk("R7 gapped frame", fcs_word, model_fcs(20));
    repeat (5) idle();
    chk("R7 idle hold", fcs_word, model_fcs(20));
  endtask

  task automatic t_ok_clear();
    t_receive(1'b0);
    repeat (3) idle();
    chk("R8 crc_ok holds", {31'h0, crc_ok}, 32'h1);
    put(1'b1, 1'b0, 8'hAA);
    idle();
    chk("R8 crc_ok cleared", {31'h0, crc_ok}, 32'h0);
  endtask

  task automatic t_back_to_back();
    for (int k = 0; k < 6; k++) fr[k] = 8'hF0 - 8'(k);
    for (int k = 0; k < 6; k++) put(k == 0, k == 5, fr[k]);
    for (int k = 0; k < 6; k++) put(k == 0, k == 5, fr[k]);
    idle();
    chk("R2 preset on sof", fcs_word, model_fcs(6));
  endtask

  task automatic t_cancel();
    load_ascii();
    send_frame(flen, 0);
    chk("R10 stream running", {31'h0, fcs_byte_valid}, 32'h1);
    put(1'b1, 1'b0, 8'h00);
    idle();
    chk("R10 stream cancelled", {31'h0, fcs_byte_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_known();
    t_stream();
    t_receive(1'b0);
    t_receive(1'b1);
    t_gaps();
    t_ok_clear();
    t_back_to_back();
    t_cancel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule